// File: doc/BRIEF.md
# Self-Timed Flux Byte Assembler

This block is the read-side bit recovery stage of a floppy disk controller. It watches a single-cycle flux pulse from the drive and turns the stream of pulses and silences into bytes. A pulse always stands for a 1 bit. A 0 bit has no pulse of its own, so a cell timer supplies it. When no pulse arrives for a full bit cell plus a guard margin of two clocks, the timer shifts in a 0. The cell length follows a two-bit speed selector that encodes the clock descriptor and the fast/slow rate.

Bytes are framed in the group-code manner. An 8-bit shift register fills from its LSB, and a byte is complete as soon as a 1 reaches the top bit, however many shifts that took. The complete byte moves into a holding register that the host reads. A read-clear strobe lets the host consume a byte: the holding register empties when the strobe meets a held byte whose top bit is set. The cell timer only runs while the read-mode qualifier is high. Flux pulses are accepted in any mode.

Top module: `flux_byte_assembler`

## Requirements
- R1: The cell length is chosen by `speed_sel_i` (bit 1 = high clock descriptor, bit 0 = fast): 2'b01 gives 12, 2'b11 gives 16, 2'b00 gives 24 and 2'b10 gives 32 clocks. If no flux pulse arrives, a 0 is shifted in on the (length+2)-th read-mode clock edge after the last shift.
- R2: A flux pulse sampled at a clock edge shifts a 1 into the LSB of the shift register and restarts the cell timer at zero.
- R3: When a shift leaves bit 7 of the shift register set, the shifted value is copied to `data_o` at that same edge and the shift register returns to zero.
- R4: If a flux pulse and a cell timeout fall on the same edge, exactly one shift happens, and it shifts a 1.
- R5: While `rd_mode_i` is low, the cell timer holds its count and shifts in no 0s. Counting resumes from the held value when `rd_mode_i` returns high.
- R6: `rd_clr_i` sampled high while `data_o[7]` is 1 and no byte completes at that edge clears `data_o` to zero at that edge.
- R7: While `rst_n` is low, `data_o`, the shift register and the cell timer are zero.
- R8: Bits arrive most significant first: the first bit shifted after the register is empty ends up in `data_o[7]`, and the last ends up in `data_o[0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flux_i | input | 1 | One-cycle pulse per detected flux transition |
| speed_sel_i | input | 2 | Cell length selector: bit 1 clock descriptor, bit 0 fast rate |
| rd_mode_i | input | 1 | High while the controller is in read mode; lets the cell timer run |
| rd_clr_i | input | 1 | Host read strobe that consumes a held byte |
| data_o | output | 8 | Holding register with the last assembled byte |

## Verification
The bench builds the block with its default cell lengths of 12, 16, 24 and 32 clocks and the guard of two clocks. It steps through all four speed codes and predicts the exact clock edge at which each byte lands. Runs of up to seven silent cells therefore pin down every timeout length. A pulse placed on the very edge of a timeout, and a long read-mode pause in the middle of a byte, reach the collision rule and the hold rule.

// File: rtl/fba_pkg.sv
package fba_pkg;
  // Largest of four cell lengths, used to size the cell counter.
  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Speed selector encoding: bit 1 = high clock descriptor, bit 0 = fast rate.
  typedef enum logic [1:0] {
    SPD_SLOW_LO = 2'b00,
    SPD_FAST_LO = 2'b01,
    SPD_SLOW_HI = 2'b10,
    SPD_FAST_HI = 2'b11
  } speed_e;
endpackage

// File: rtl/fba_cell_timer.sv
module fba_cell_timer
  import fba_pkg::*;
#(
  parameter int unsigned CNT_W   = 6,
  parameter int unsigned LEN_SL  = 24,
  parameter int unsigned LEN_FL  = 12,
  parameter int unsigned LEN_SH  = 32,
  parameter int unsigned LEN_FH  = 16,
  parameter int unsigned GUARD   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flux_i,
  input  logic             rd_mode_i,
  input  logic [1:0]       speed_sel_i,
  output logic             zero_shift_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   limit;
  logic [CNT_W:0]   cnt_inc;
  logic             cnt_en;
  logic             timeout;

  always_comb begin
    unique case (speed_e'(speed_sel_i))
      SPD_SLOW_LO: limit = (CNT_W+1)'(LEN_SL + GUARD);
      SPD_FAST_LO: limit = (CNT_W+1)'(LEN_FL + GUARD);
      SPD_SLOW_HI: limit = (CNT_W+1)'(LEN_SH + GUARD);
      default:     limit = (CNT_W+1)'(LEN_FH + GUARD);
    endcase
  end

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
    // >= keeps the timer bounded if the speed drops mid-cell.
    timeout = rd_mode_i && !flux_i && (cnt_inc >= limit);
    cnt_en  = flux_i || rd_mode_i;
    if (flux_i || timeout) cnt_d = '0;
    else                   cnt_d = cnt_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_shift_o = timeout;
  assign cnt_o        = cnt_q;
endmodule

// File: rtl/fba_shifter.sv
module fba_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              one_i,
  input  logic              zero_i,
  output logic              done_o,
  output logic [DATA_W-1:0] byte_o,
  output logic [DATA_W-1:0] sh_o
);
  logic [DATA_W-1:0] sh_q, sh_d, sh_next;
  logic              sh_en;

  always_comb begin
    sh_en   = one_i || zero_i;
    sh_next = {sh_q[DATA_W-2:0], one_i};
    done_o  = sh_en && sh_next[DATA_W-1];
    sh_d    = done_o ? '0 : sh_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign byte_o = sh_next;
  assign sh_o   = sh_q;
endmodule

// File: rtl/fba_data_hold.sv
module fba_data_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] data_q, data_d;
  logic              data_en;

  always_comb begin
    // A completing byte takes priority over a consuming read.
    data_en = load_i || (clr_i && data_q[DATA_W-1]);
    data_d  = load_i ? byte_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign data_o = data_q;
endmodule

// File: rtl/flux_byte_assembler.sv
module flux_byte_assembler
  import fba_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_SL = 24,
  parameter int unsigned LEN_FL = 12,
  parameter int unsigned LEN_SH = 32,
  parameter int unsigned LEN_FH = 16,
  parameter int unsigned GUARD  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flux_i,
  input  logic [1:0]        speed_sel_i,
  input  logic              rd_mode_i,
  input  logic              rd_clr_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned MAX_LIM = max4(LEN_SL, LEN_FL, LEN_SH, LEN_FH) + GUARD;
  localparam int unsigned CNT_W   = $clog2(MAX_LIM + 1);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;
  logic                   zero_shift;
  logic                   byte_done;
  logic [DATA_W-1:0]      byte_val;
  logic [DATA_W-1:0]      shift_q;
  logic [CNT_W-1:0]       cell_cnt;

  // Reset asserts at once and leaves after SYNC_STAGES clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  fba_cell_timer #(
    .CNT_W(CNT_W), .LEN_SL(LEN_SL), .LEN_FL(LEN_FL),
    .LEN_SH(LEN_SH), .LEN_FH(LEN_FH), .GUARD(GUARD)
  ) u_timer (
    .clk(clk), .rst_n(rst_int_n), .flux_i(flux_i), .rd_mode_i(rd_mode_i),
    .speed_sel_i(speed_sel_i), .zero_shift_o(zero_shift), .cnt_o(cell_cnt)
  );

  fba_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .one_i(flux_i), .zero_i(zero_shift),
    .done_o(byte_done), .byte_o(byte_val), .sh_o(shift_q)
  );

  fba_data_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_int_n), .load_i(byte_done), .byte_i(byte_val),
    .clr_i(rd_clr_i), .data_o(data_o)
  );
endmodule

// File: rtl/fba_checker.sv
module fba_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flux,
  input logic              rd_mode,
  input logic              rd_clr,
  input logic              load,
  input logic [DATA_W-1:0] data,
  input logic [DATA_W-1:0] shreg,
  input logic [CNT_W-1:0]  cnt
);
  assert_reset_clear_R7: assert property (@(posedge clk)
    !rst_n |-> (data == '0 && shreg == '0 && cnt == '0));

  assert_flux_single_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flux |=> (cnt == '0 && (shreg[0] || shreg == '0)));

  assert_timer_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_mode && !flux) |=> $stable(cnt) && $stable(shreg));

  assert_load_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (data[DATA_W-1] && shreg == '0));

  assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && data[DATA_W-1] && !load) |=> data == '0);
endmodule

bind flux_byte_assembler fba_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flux(flux_i), .rd_mode(rd_mode_i), .rd_clr(rd_clr_i),
  .load(byte_done), .data(data_o), .shreg(shift_q), .cnt(cell_cnt)
);

// File: tb/tb_flux_byte_assembler.sv
module tb_flux_byte_assembler;
  typedef struct {
    logic [7:0] val;
    int         edge_no;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       flux;
  logic [1:0] speed;
  logic       rd_mode;
  logic       rd_clr;
  logic [7:0] data_o;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_bad = 0;
  item_t sb[$];

  flux_byte_assembler dut (
    .clk(clk), .rst_n(rst_n), .flux_i(flux), .speed_sel_i(speed),
    .rd_mode_i(rd_mode), .rd_clr_i(rd_clr), .data_o(data_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int cell_len(input logic [1:0] s);
    case (s)
      2'b00: return 24;
      2'b01: return 12;
      2'b10: return 32;
      default: return 16;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // Pulse flux so that it is sampled at clock edge number e.
  task automatic pulse_at(input int e);
    while (cyc < e - 1) @(negedge clk);
    flux = 1'b1;
    @(negedge clk);
    flux = 1'b0;
  endtask

  // Driver: send one framed byte MSB first, push its value and landing edge.
  task automatic send_byte(input logic [7:0] b, input string tag);
    int t;
    int lim;
    item_t it;
    lim = cell_len(speed) + 2;
    t = cyc + 2;
    for (int i = 6; i >= 0; i--) begin
      if (b[i]) t = t + 3;
      else      t = t + lim;
    end
    it.val = b; it.edge_no = t; it.tag = tag;
    sb.push_back(it);
    t = cyc + 2;
    pulse_at(t);
    for (int i = 6; i >= 0; i--) begin
      if (b[i]) begin t = t + 3; pulse_at(t); end
      else      t = t + lim;
    end
    while (cyc < t + 4) @(negedge clk);
  endtask

  // Monitor: compare each landed byte, then consume it with the read strobe.
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (rst_n && data_o[7]) begin
        if (sb.size() == 0) begin
          check(1'b0, "R3 unexpected byte", data_o, 0);
        end else begin
          it = sb.pop_front();
          check(data_o == it.val, {it.tag, " R8 value"}, data_o, it.val);
          if (it.edge_no >= 0)
            check(cyc == it.edge_no, {it.tag, " R1 landing edge"}, cyc, it.edge_no);
        end
        rd_clr = 1'b1;
        @(negedge clk);
        rd_clr = 1'b0;
        check(data_o == 8'h00, "R6 read clear", data_o, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=<200000", cyc);
    summary();
  end

  initial begin
    int s;
    item_t it;
    rst_n = 1'b0; flux = 1'b0; speed = 2'b00; rd_mode = 1'b1; rd_clr = 1'b0;
    repeat (4) @(negedge clk);
    check(data_o == 8'h00, "R7 reset value", data_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(data_o == 8'h00, "R7 idle after reset", data_o, 0);

    for (int m = 0; m < 4; m++) begin
      speed = 2'(m);
      repeat (3) @(negedge clk);
      send_byte(8'h80, "R1 all-zero tail");
      send_byte(8'hD5, "R8 mixed");
      send_byte(8'hFF, "R2 all ones");
      send_byte(8'h96, "R3 gcr");
    end

    // R4: second pulse lands exactly on the 14th edge (12-clock cell + 2).
    speed = 2'b01;
    repeat (3) @(negedge clk);
    s = cyc + 2;
    it.val = 8'hFF; it.edge_no = s + 14 + 18; it.tag = "R4 collision";
    sb.push_back(it);
    pulse_at(s);
    pulse_at(s + 14);
    for (int k = 1; k <= 6; k++) pulse_at(s + 14 + 3 * k);
    repeat (6) @(negedge clk);

    // R5: pause the timer for 200 edges right after the leading 1.
    speed = 2'b11;
    repeat (3) @(negedge clk);
    s = cyc + 2;
    it.val = 8'h80; it.edge_no = s + 200 + 7 * 18; it.tag = "R5 pause";
    sb.push_back(it);
    pulse_at(s);
    rd_mode = 1'b0;
    while (cyc < s + 200) @(negedge clk);
    check(data_o == 8'h00, "R5 no zeros while paused", data_o, 0);
    rd_mode = 1'b1;
    while (cyc < s + 200 + 7 * 18 + 4) @(negedge clk);

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R3 all bytes landed", sb.size(), 0);
    summary();
  end
endmodule